// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block is the logic core of a bidirectional bus transceiver with two independent 18-bit paths: one carries the A bus towards B, the other carries the B bus towards A. Each path holds a storage register. The register runs in one of three modes. It can pass the input straight through (transparent), keep its last value (hold), or take a new value on a rising edge of the path's own strobe (capture). Every control is sampled in a single fast system clock domain. The rising edge of a path strobe is found by comparing the current sample with the one before it.

Each path presents a data bus and a separate one-bit drive enable, so a pad wrapper above this block can build the tri-state buffers. The two directions use enables of opposite polarity. The A-to-B enable is active high and the B-to-A enable is active low. The wrapper or the system must never let both directions drive the same wires at once.

Top module: `duplex_hold_xcvr`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, both stored values become zero and both drive enables become 0 after that edge, whatever the other inputs are.
- R2: When a path's latch enable is 1 at an edge, that path's output after the edge equals its input bus as sampled at that edge (one cycle of latency).
- R3: When a path's latch enable is 0 and no strobe rise is detected at an edge, that path's output keeps its value across the edge, even if the input bus changes.
- R4: A strobe rise means the strobe sample is 1 at this edge and was 0 at the previous edge. With the latch enable at 0, a rise captures the input bus of that edge, and the output shows it after the edge. A strobe that stays high or falls captures nothing.
- R5: The B-side drive enable `b_drv` equals `ab_oe` as sampled one edge earlier (active high).
- R6: The A-side drive enable `a_drv` equals the inverse of `ba_oe_n` as sampled one edge earlier (active low).
- R7: The two paths are independent. The controls and data of one path never change the output or drive enable of the other.
- R8: During reset the previous strobe sample is taken as 1. A strobe that is already high on the first edge after reset therefore captures nothing.
- R9: Turning a path's drive enable off leaves its stored value in place and visible on its output bus. Turning the enable back on drives that same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every control is sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 18 | A bus as seen at the A pads |
| ab_le | input | 1 | A-to-B latch enable; 1 selects transparent mode |
| ab_strobe | input | 1 | A-to-B capture strobe; a detected rise captures `a_in` |
| ab_oe | input | 1 | A-to-B output enable, active high |
| b_in | input | 18 | B bus as seen at the B pads |
| ba_le | input | 1 | B-to-A latch enable; 1 selects transparent mode |
| ba_strobe | input | 1 | B-to-A capture strobe; a detected rise captures `b_in` |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Data to drive onto the B bus |
| b_drv | output | 1 | 1 when the B pads should drive `b_out` |
| a_out | output | 18 | Data to drive onto the A bus |
| a_drv | output | 1 | 1 when the A pads should drive `a_out` |

## Verification
The assertions assume the strobes and latch enables are already synchronous to `clk`. They also assume each input is stable for a whole cycle, so every sampled value is meaningful. The stimulus changes inputs only on the falling edge of `clk`. Hold with the latch enable low and the strobe low is only guaranteed when the strobe was high as the latch enable fell. The stimulus keeps to that order when it parks a strobe low, and the checker tracks but does not flag the other case. The stimulus never enables both directions in the same cycle, and the bench reports any cycle where both drive enables are 1 as contention.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the dual-direction transceiver.
// Assumes: nothing beyond IEEE 1800-2017.
package xcvr_pkg;

    localparam int XCVR_DATA_W = 18;

    // Operating mode of one path's storage register for the current cycle.
    typedef enum logic [1:0] {
        MODE_HOLD    = 2'd0,
        MODE_PASS    = 2'd1,
        MODE_CAPTURE = 2'd2
    } store_mode_e;

    // Transparent mode wins over an edge; otherwise an edge captures.
    function automatic store_mode_e pick_mode(input logic le, input logic rise);
        if (le)
            return MODE_PASS;
        else if (rise)
            return MODE_CAPTURE;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_edge_sense.sv
// Finds rising edges of a synchronous strobe by keeping its previous sample.
// Assumes: `level` is already synchronous to clk. Reset loads RST_PREV so
// a strobe held high through reset is not seen as a new edge.
module xcvr_edge_sense #(
    parameter logic RST_PREV = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);

    logic prev_q;

    // Keep the strobe sample from the last clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= RST_PREV;
        else
            prev_q <= level;
    end

    // A rise is this sample high with the previous one low.
    always_comb begin
        rise = level & ~prev_q;
    end

endmodule

// File: rtl/xcvr_store.sv
// Storage register of one path, loaded according to the selected mode.
// Assumes: mode is decoded from inputs sampled on the same clk edge.
module xcvr_store #(
    parameter int W = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  xcvr_pkg::store_mode_e     mode,
    input  logic [W-1:0]              din,
    output logic [W-1:0]              dout
);
    import xcvr_pkg::*;

    logic [W-1:0] data_q;
    logic [W-1:0] data_d;

    // Choose the next stored value from the mode.
    always_comb begin
        unique case (mode)
            MODE_PASS,
            MODE_CAPTURE: data_d = din;
            default:      data_d = data_q;
        endcase
    end

    // Update storage, clearing it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else
            data_q <= data_d;
    end

    // Present the stored value.
    always_comb begin
        dout = data_q;
    end

endmodule

// File: rtl/xcvr_enable.sv
// Registers a path's output enable, folding its pin polarity to active high.
// Assumes: ACTIVE_HIGH says which level of oe_pin asks for drive.
module xcvr_enable #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_pin,
    output logic drv
);

    logic want;
    logic drv_q;

    generate
        if (ACTIVE_HIGH) begin : g_pos
            // Pin high requests drive.
            always_comb want = oe_pin;
        end else begin : g_neg
            // Pin low requests drive.
            always_comb want = ~oe_pin;
        end
    endgenerate

    // Align the enable with the data register; off during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drv_q <= 1'b0;
        else
            drv_q <= want;
    end

    // Present the registered enable.
    always_comb begin
        drv = drv_q;
    end

endmodule

// File: rtl/xcvr_lane.sv
// One direction of the transceiver: edge sense, mode decode, storage, enable.
// Assumes: le, strobe and oe are synchronous to clk.
module xcvr_lane #(
    parameter int W           = 18,
    parameter bit OE_ACT_HIGH = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         le,
    input  logic         strobe,
    input  logic         oe,
    output logic [W-1:0] dout,
    output logic         drv
);
    import xcvr_pkg::*;

    logic        rise;
    store_mode_e mode;

    xcvr_edge_sense #(.RST_PREV(1'b1)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (strobe),
        .rise  (rise)
    );

    // Decode this cycle's storage mode.
    always_comb begin
        mode = pick_mode(le, rise);
    end

    xcvr_store #(.W(W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .din   (din),
        .dout  (dout)
    );

    xcvr_enable #(.ACTIVE_HIGH(OE_ACT_HIGH)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe_pin (oe),
        .drv    (drv)
    );

endmodule

// File: rtl/duplex_hold_xcvr.sv
// Dual-direction latch/register transceiver core. The A-to-B lane uses an
// active-high enable and the B-to-A lane an active-low one. Data and drive
// enables are separate outputs for a pad wrapper.
// Assumes: all controls synchronous to clk; the system never enables both.
module duplex_hold_xcvr #(
    parameter int W = xcvr_pkg::XCVR_DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    input  logic         ab_le,
    input  logic         ab_strobe,
    input  logic         ab_oe,
    input  logic [W-1:0] b_in,
    input  logic         ba_le,
    input  logic         ba_strobe,
    input  logic         ba_oe_n,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    output logic [W-1:0] a_out,
    output logic         a_drv
);

    xcvr_lane #(.W(W), .OE_ACT_HIGH(1'b1)) u_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (a_in),
        .le     (ab_le),
        .strobe (ab_strobe),
        .oe     (ab_oe),
        .dout   (b_out),
        .drv    (b_drv)
    );

    xcvr_lane #(.W(W), .OE_ACT_HIGH(1'b0)) u_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (b_in),
        .le     (ba_le),
        .strobe (ba_strobe),
        .oe     (ba_oe_n),
        .dout   (a_out),
        .drv    (a_drv)
    );

endmodule

// File: rtl/xcvr_checker.sv
// Property checker for duplex_hold_xcvr, attached by bind.
// Assumes: inputs change only between clock edges.
module xcvr_checker #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic         ab_le,
    input logic         ab_strobe,
    input logic         ab_oe,
    input logic [W-1:0] b_in,
    input logic         ba_le,
    input logic         ba_strobe,
    input logic         ba_oe_n,
    input logic [W-1:0] b_out,
    input logic         b_drv,
    input logic [W-1:0] a_out,
    input logic         a_drv
);

    logic ab_seen, ba_seen;
    logic ab_rise, ba_rise;
    logic ab_loose, ba_loose;

    // Checker-side record of the strobe samples (R8: taken as 1 in reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ab_seen <= 1'b1;
            ba_seen <= 1'b1;
        end else begin
            ab_seen <= ab_strobe;
            ba_seen <= ba_strobe;
        end
    end

    assign ab_rise = ab_strobe & ~ab_seen;
    assign ba_rise = ba_strobe & ~ba_seen;

    // Tracks the unguaranteed hold: latch enable fell while strobe was low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ab_loose <= 1'b0;
            ba_loose <= 1'b0;
        end else begin
            ab_loose <= !ab_le && (ab_loose || (!ab_strobe && $past(ab_le)));
            ba_loose <= !ba_le && (ba_loose || (!ba_strobe && $past(ba_le)));
        end
    end

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (b_out == '0 && a_out == '0 && !b_drv && !a_drv));

    assert_ab_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |=> b_out == $past(a_in));
    assert_ba_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |=> a_out == $past(b_in));

    assert_ab_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !ab_rise) |=> $stable(b_out));
    assert_ba_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && !ba_rise) |=> $stable(a_out));

    assert_ab_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && ab_rise) |=> b_out == $past(a_in));
    assert_ba_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && ba_rise) |=> a_out == $past(b_in));

    assert_b_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> b_drv == $past(ab_oe));
    assert_a_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> a_drv == !$past(ba_oe_n));

endmodule

bind duplex_hold_xcvr xcvr_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_in      (a_in),
    .ab_le     (ab_le),
    .ab_strobe (ab_strobe),
    .ab_oe     (ab_oe),
    .b_in      (b_in),
    .ba_le     (ba_le),
    .ba_strobe (ba_strobe),
    .ba_oe_n   (ba_oe_n),
    .b_out     (b_out),
    .b_drv     (b_drv),
    .a_out     (a_out),
    .a_drv     (a_drv)
);

// File: tb/sim_duplex_hold_xcvr.sv
// Scoreboard bench: a driver task applies one cycle of stimulus and queues
// the outputs the requirements predict; a monitor compares after each edge.
module sim_duplex_hold_xcvr;

    localparam int W = 18;

    typedef struct {
        logic [W-1:0] b_val;
        logic         b_en;
        logic [W-1:0] a_val;
        logic         a_en;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         ab_le = 1'b0, ab_strobe = 1'b0, ab_oe = 1'b0;
    logic         ba_le = 1'b0, ba_strobe = 1'b0, ba_oe_n = 1'b1;
    logic [W-1:0] b_out, a_out;
    logic         b_drv, a_drv;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Requirement model state
    logic [W-1:0] m_b = '0, m_a = '0;
    logic         m_bdrv = 1'b0, m_adrv = 1'b0;
    logic         m_abprev = 1'b1, m_baprev = 1'b1;

    always #2 clk = ~clk;

    duplex_hold_xcvr #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .ab_le(ab_le), .ab_strobe(ab_strobe), .ab_oe(ab_oe),
        .b_in(b_in), .ba_le(ba_le), .ba_strobe(ba_strobe), .ba_oe_n(ba_oe_n),
        .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
    );

    // Drive one cycle, predict outputs after the next edge, wait to negedge.
    task automatic step(input logic rst, input logic [W-1:0] av, input logic ale,
                        input logic astb, input logic aoe, input logic [W-1:0] bv,
                        input logic ble, input logic bstb, input logic boe_n,
                        input string tag);
        exp_t e;
        rst_n = rst; a_in = av; ab_le = ale; ab_strobe = astb; ab_oe = aoe;
        b_in = bv; ba_le = ble; ba_strobe = bstb; ba_oe_n = boe_n;
        if (!rst) begin
            m_b = '0; m_a = '0; m_bdrv = 1'b0; m_adrv = 1'b0;
            m_abprev = 1'b1; m_baprev = 1'b1;
        end else begin
            if (ale || (astb && !m_abprev)) m_b = av;
            if (ble || (bstb && !m_baprev)) m_a = bv;
            m_abprev = astb; m_baprev = bstb;
            m_bdrv = aoe; m_adrv = !boe_n;
        end
        e.b_val = m_b; e.b_en = m_bdrv; e.a_val = m_a; e.a_en = m_adrv; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare queued predictions shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_vec++;
                if (b_out !== e.b_val || b_drv !== e.b_en ||
                    a_out !== e.a_val || a_drv !== e.a_en) begin
                    n_bad++;
                    $display("FAIL %s: b_out=%h b_drv=%b a_out=%h a_drv=%b expected %h %b %h %b",
                             e.tag, b_out, b_drv, a_out, a_drv,
                             e.b_val, e.b_en, e.a_val, e.a_en);
                end
            end
            if (b_drv === 1'b1 && a_drv === 1'b1) begin
                n_vec++;
                n_bad++;
                $display("FAIL R5 R6 bus contention: b_drv=%b a_drv=%b expected not both 1",
                         b_drv, a_drv);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset with every input active
        step(0, 18'h3FFFF, 1, 1, 1, 18'h2AAAA, 1, 1, 0, "R1");
        step(0, 18'h15555, 1, 1, 1, 18'h2AAAA, 1, 1, 0, "R1");
        // R8: strobes high right after reset capture nothing
        step(1, 18'h12345, 0, 1, 0, 18'h0F0F0, 0, 1, 1, "R8");
        step(1, 18'h12346, 0, 1, 0, 18'h0F0F1, 0, 1, 1, "R8");
        // R2: transparent A-to-B with enable on, several patterns
        step(1, 18'h2AAAA, 1, 1, 1, 18'h00000, 0, 1, 1, "R2");
        step(1, 18'h15555, 1, 1, 1, 18'h00000, 0, 1, 1, "R2");
        step(1, 18'h3FFFF, 1, 0, 1, 18'h00000, 0, 1, 1, "R2");
        step(1, 18'h20001, 1, 1, 1, 18'h00000, 0, 1, 1, "R2");
        // R3: latch enable falls with strobe high, data moves, hold
        step(1, 18'h0BEEF, 0, 1, 1, 18'h00000, 0, 1, 1, "R3");
        step(1, 18'h1CAFE, 0, 1, 1, 18'h00000, 0, 1, 1, "R3");
        step(1, 18'h03333, 0, 0, 1, 18'h00000, 0, 1, 1, "R3");
        step(1, 18'h04444, 0, 0, 1, 18'h00000, 0, 1, 1, "R3");
        // R4: rise captures, staying high and falling do not
        step(1, 18'h05A5A, 0, 1, 1, 18'h00000, 0, 1, 1, "R4");
        step(1, 18'h06B6B, 0, 1, 1, 18'h00000, 0, 1, 1, "R4");
        step(1, 18'h07C7C, 0, 0, 1, 18'h00000, 0, 1, 1, "R4");
        step(1, 18'h38001, 0, 1, 1, 18'h00000, 0, 1, 1, "R4");
        // R9: drive off keeps stored value visible, back on drives it
        step(1, 18'h11111, 0, 1, 0, 18'h00000, 0, 1, 1, "R9");
        step(1, 18'h22222, 0, 1, 0, 18'h00000, 0, 1, 1, "R9");
        step(1, 18'h22222, 0, 1, 1, 18'h00000, 0, 1, 1, "R9");
        // R6: B-to-A with active-low enable; A-to-B released first (R5)
        step(1, 18'h00000, 0, 1, 0, 18'h00000, 0, 1, 1, "R5");
        step(1, 18'h00000, 0, 1, 0, 18'h1F00F, 1, 1, 0, "R6");
        step(1, 18'h00000, 0, 1, 0, 18'h2C0C0, 1, 1, 0, "R6");
        // R7: heavy A-to-B activity while B-to-A holds
        step(1, 18'h3ABCD, 1, 0, 0, 18'h01234, 0, 1, 0, "R7");
        step(1, 18'h2DCBA, 0, 1, 0, 18'h05678, 0, 1, 0, "R7");
        step(1, 18'h1EEEE, 0, 0, 0, 18'h09ABC, 0, 0, 0, "R7");
        // R4: B-to-A capture on rise, then hold while B data moves (R3)
        step(1, 18'h1EEEE, 0, 0, 0, 18'h13579, 0, 1, 0, "R4");
        step(1, 18'h1EEEE, 0, 0, 0, 18'h2468A, 0, 1, 0, "R3");
        // R7: B-to-A activity while A-to-B holds, with B drive on
        step(1, 18'h00001, 0, 0, 1, 18'h3F0F0, 1, 0, 1, "R7");
        step(1, 18'h00002, 0, 0, 1, 18'h00F0F, 1, 0, 1, "R7");
        // R1: reset mid-run clears everything
        step(0, 18'h3FFFF, 1, 1, 1, 18'h3FFFF, 0, 0, 1, "R1");
        step(1, 18'h00000, 0, 0, 0, 18'h00000, 0, 0, 1, "R3");
        step(1, 18'h00000, 0, 0, 0, 18'h00000, 0, 0, 1, "R3");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule